// File: doc/BRIEF.md
# Boundary-Scan Wrapped Dual Nine-Bit Latch

The block holds two independent nine-bit data channels, A and B. Each channel is a level-sensitive transparent latch with its own latch enable and its own active-low output enable. Each output is shown as a data value plus a drive-enable flag, not as a true tri-state pin.

All pins sit inside a 42-cell boundary-scan chain clocked by `tck`. A separate test-port controller supplies the capture, shift and update strobes and the control-mode select as plain inputs. Observe-only cells sample the data inputs and control pins. Observe-and-control cells sit on every data output and on the two internal active-high output enables. When control mode is selected, these cells override the values the core would drive.

Top module: `scan_dual_latch`

## Requirements
- R1: While `ctl_mode`=0 and a channel's latch enable is 1, that channel's `x_dout` equals its `x_din`.
- R2: When a channel's latch enable goes to 0, `x_dout` keeps the last value it passed and ignores later `x_din` changes (with `ctl_mode`=0).
- R3: With `ctl_mode`=0, `x_drv` is 1 when `x_oe_n`=0 and 0 when `x_oe_n`=1. While undriven, the latch still loads new data, and that data appears once the enable returns.
- R4: The A and B channels are independent: stimulus on one never changes the other's outputs.
- R5: When `cap_en`=1 at a rising `tck` edge, the chain loads the core-side values. Bit 41 is `a_oe_n`, bit 40 is `a_le`, bit 39 is the internal A enable (= NOT `a_oe_n`). Bit 38 is `b_oe_n`, bit 37 is `b_le`, bit 36 is the internal B enable. Bit 35-i is `a_din[i]` and bit 26-i is `b_din[i]`. Bit 17-i is bit i of the A latch and bit 8-i is bit i of the B latch.
- R6: When `shift_en`=1 at a rising `tck` edge, the chain moves one place toward bit 0, and `tdi` enters bit 41. A pattern shifted in reappears on `tdo` exactly 42 shifts later, bit 0 first.
- R7: `tdo` presents chain bit 0 and changes only on a falling `tck` edge. After a rising-edge capture or shift, it keeps its old value until the next falling edge.
- R8: When `upd_en`=1 at a falling `tck` edge, the control cells copy their shift stage into their update stage. With `ctl_mode`=1, `a_dout[i]` is update bit 17-i, `b_dout[i]` is update bit 8-i, `a_drv` is update bit 39 and `b_drv` is update bit 36.
- R9: While `upd_en`=0, the update stage holds. Capture and shift do not disturb the outputs in control mode.
- R10: With `ctl_mode`=0, the outputs show the core values whatever the update stage holds.
- R11: `rst_n`=0 at a clock edge clears every update and shift stage and `tdo`. In control mode, every output and drive flag then reads 0.
- R12: In control mode the latches keep following their inputs, and a capture records the latch contents rather than the overriding values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock; capture/shift on rise, update and `tdo` on fall |
| rst_n | input | 1 | Synchronous active-low reset of the scan stages |
| cap_en | input | 1 | Capture strobe from the test-port controller |
| shift_en | input | 1 | Shift strobe from the test-port controller |
| upd_en | input | 1 | Update strobe from the test-port controller |
| ctl_mode | input | 1 | Selects update-stage values onto outputs and enables |
| tdi | input | 1 | Serial scan input |
| a_le | input | 1 | Channel A latch enable, active high |
| a_oe_n | input | 1 | Channel A output enable, active low |
| a_din | input | DATA_W | Channel A data input |
| b_le | input | 1 | Channel B latch enable, active high |
| b_oe_n | input | 1 | Channel B output enable, active low |
| b_din | input | DATA_W | Channel B data input |
| a_dout | output | DATA_W | Channel A output value |
| a_drv | output | 1 | Channel A drive-enable flag |
| b_dout | output | DATA_W | Channel B output value |
| b_drv | output | 1 | Channel B drive-enable flag |
| tdo | output | 1 | Serial scan output |

## Verification
On every clock, the assertions check the following:
- Latch transparency and hold, channel by channel.
- The drive flags follow the inverted output-enable pins in normal mode.
- The overridden outputs stay still in control mode unless an update strobe was seen.
- All overridden values read zero right after reset.

The bench scenarios cover what the assertions cannot see:
- The captured bit order of the 42-bit chain and the 42-shift latency from `tdi` to `tdo`.
- The falling-edge timing of `tdo`.
- The mapping of update bits onto pins.
- The latch still loading while undriven or overridden.

// File: rtl/scan_latch_pkg.sv
// Package: chain geometry shared by the scan wrapper modules.
// Assumes six control cells sit above four data groups of DATA_W bits each.
package scan_latch_pkg;

    localparam int NUM_CTL_CELLS = 6;

    // Total chain length for a given data width.
    function automatic int chain_len(input int w);
        return NUM_CTL_CELLS + 4 * w;
    endfunction

    // True for cells that can override a system value: the two internal
    // enables and every data-output position (the lowest 2*w bits).
    function automatic bit cell_has_update(input int idx, input int w);
        int len;
        len = chain_len(w);
        return (idx == len - 3) || (idx == len - 6) || (idx < 2 * w);
    endfunction

endpackage

// File: rtl/latch_bank.sv
// Module: latch_bank
// One channel of level-sensitive storage: passes d while le is high, holds
// when le is low. Assumes le is glitch-free at the system level.
module latch_bank #(
    parameter int W = 9
) (
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Transparent storage for the whole channel.
    always_latch begin
        if (le) q = d;
    end

endmodule

// File: rtl/bscan_cell.sv
// Module: bscan_cell
// One boundary-scan position. A shift stage captures sys_in or takes
// scan_in on rising tck. When HAS_UPDATE is set, an update stage loads on
// falling tck and may replace sys_in at sys_out in control mode.
// Assumes cap_en and shift_en are never high together.
module bscan_cell #(
    parameter bit HAS_UPDATE = 1'b0
) (
    input  logic tck,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shift_en,
    input  logic upd_en,
    input  logic ctl_mode,
    input  logic sys_in,
    input  logic scan_in,
    output logic scan_out,
    output logic sys_out
);

    logic shf_q;

    // Shift stage: capture has priority over shift.
    always_ff @(posedge tck) begin
        if (!rst_n)        shf_q <= 1'b0;
        else if (cap_en)   shf_q <= sys_in;
        else if (shift_en) shf_q <= scan_in;
    end

    assign scan_out = shf_q;

    generate
        if (HAS_UPDATE) begin : g_ctl
            logic upd_q;

            // Update stage: loads from the shift stage on the falling edge.
            always_ff @(negedge tck) begin
                if (!rst_n)      upd_q <= 1'b0;
                else if (upd_en) upd_q <= shf_q;
            end

            assign sys_out = ctl_mode ? upd_q : sys_in;
        end else begin : g_obs
            logic unused_ctl;
            assign unused_ctl = upd_en | ctl_mode;
            assign sys_out    = sys_in;
        end
    endgenerate

endmodule

// File: rtl/scan_chain.sv
// Module: scan_chain
// Strings chain_len(W) cells from tdi (top bit) to tdo (bit 0) and
// re-times the last stage onto tdo at the falling tck edge.
// Assumes the cell kinds given by scan_latch_pkg::cell_has_update.
module scan_chain
    import scan_latch_pkg::*;
#(
    parameter  int W   = 9,
    localparam int LEN = NUM_CTL_CELLS + 4 * W
) (
    input  logic           tck,
    input  logic           rst_n,
    input  logic           cap_en,
    input  logic           shift_en,
    input  logic           upd_en,
    input  logic           ctl_mode,
    input  logic           tdi,
    input  logic [LEN-1:0] sys_in,
    output logic [LEN-1:0] sys_out,
    output logic           tdo
);

    logic [LEN:0] link;
    assign link[LEN] = tdi;

    generate
        for (genvar k = 0; k < LEN; k++) begin : g_cell
            bscan_cell #(
                .HAS_UPDATE(cell_has_update(k, W))
            ) u_cell (
                .tck     (tck),
                .rst_n   (rst_n),
                .cap_en  (cap_en),
                .shift_en(shift_en),
                .upd_en  (upd_en),
                .ctl_mode(ctl_mode),
                .sys_in  (sys_in[k]),
                .scan_in (link[k+1]),
                .scan_out(link[k]),
                .sys_out (sys_out[k])
            );
        end
    endgenerate

    // Serial output changes on the falling edge only.
    always_ff @(negedge tck) begin
        if (!rst_n) tdo <= 1'b0;
        else        tdo <= link[0];
    end

endmodule

// File: rtl/scan_dual_latch.sv
// Module: scan_dual_latch
// Two independent latch channels wrapped in one boundary-scan chain.
// Outputs are value plus drive flag. Test-port state decoding is external
// and arrives as strobes. Assumes the strobes change away from tck edges.
module scan_dual_latch
    import scan_latch_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              shift_en,
    input  logic              upd_en,
    input  logic              ctl_mode,
    input  logic              tdi,
    input  logic              a_le,
    input  logic              a_oe_n,
    input  logic [DATA_W-1:0] a_din,
    input  logic              b_le,
    input  logic              b_oe_n,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_drv,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_drv,
    output logic              tdo
);

    localparam int LEN     = chain_len(DATA_W);
    localparam int I_A_OEN = LEN - 1;
    localparam int I_A_LE  = LEN - 2;
    localparam int I_A_EN  = LEN - 3;
    localparam int I_B_OEN = LEN - 4;
    localparam int I_B_LE  = LEN - 5;
    localparam int I_B_EN  = LEN - 6;
    localparam int A_IN0   = LEN - 7;
    localparam int B_IN0   = A_IN0 - DATA_W;
    localparam int A_OUT0  = B_IN0 - DATA_W;
    localparam int B_OUT0  = A_OUT0 - DATA_W;

    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;
    logic [LEN-1:0]    sys_to_chain;
    logic [LEN-1:0]    sys_from_chain;

    latch_bank #(.W(DATA_W)) u_lat_a (.le(a_le), .d(a_din), .q(a_q));
    latch_bank #(.W(DATA_W)) u_lat_b (.le(b_le), .d(b_din), .q(b_q));

    // Control-pin and internal-enable positions of the chain.
    assign sys_to_chain[I_A_OEN] = a_oe_n;
    assign sys_to_chain[I_A_LE]  = a_le;
    assign sys_to_chain[I_A_EN]  = ~a_oe_n;
    assign sys_to_chain[I_B_OEN] = b_oe_n;
    assign sys_to_chain[I_B_LE]  = b_le;
    assign sys_to_chain[I_B_EN]  = ~b_oe_n;

    // Data positions: bit 0 of each group sits at the group's top index.
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_map
            assign sys_to_chain[A_IN0 - i]  = a_din[i];
            assign sys_to_chain[B_IN0 - i]  = b_din[i];
            assign sys_to_chain[A_OUT0 - i] = a_q[i];
            assign sys_to_chain[B_OUT0 - i] = b_q[i];
            assign a_dout[i] = sys_from_chain[A_OUT0 - i];
            assign b_dout[i] = sys_from_chain[B_OUT0 - i];
        end
    endgenerate

    assign a_drv = sys_from_chain[I_A_EN];
    assign b_drv = sys_from_chain[I_B_EN];

    logic unused_obs_bits;
    assign unused_obs_bits = ^{sys_from_chain[I_A_OEN], sys_from_chain[I_A_LE],
                               sys_from_chain[I_B_OEN], sys_from_chain[I_B_LE],
                               sys_from_chain[A_IN0:A_OUT0+1]};

    scan_chain #(.W(DATA_W)) u_chain (
        .tck     (tck),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .shift_en(shift_en),
        .upd_en  (upd_en),
        .ctl_mode(ctl_mode),
        .tdi     (tdi),
        .sys_in  (sys_to_chain),
        .sys_out (sys_from_chain),
        .tdo     (tdo)
    );

endmodule

// File: rtl/scan_dual_latch_chk.sv
// Module: scan_dual_latch_chk
// Port-level properties of scan_dual_latch, sampled on rising tck.
// Assumes data and strobe inputs change only between tck edges.
module scan_dual_latch_chk #(
    parameter int DATA_W = 9
) (
    input logic              tck,
    input logic              rst_n,
    input logic              upd_en,
    input logic              ctl_mode,
    input logic              a_le,
    input logic              a_oe_n,
    input logic [DATA_W-1:0] a_din,
    input logic              b_le,
    input logic              b_oe_n,
    input logic [DATA_W-1:0] b_din,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_drv,
    input logic [DATA_W-1:0] b_dout,
    input logic              b_drv
);

    p_transparent_a_r1: assert property (@(posedge tck) disable iff (!rst_n)
        (!ctl_mode && a_le) |-> (a_dout == a_din));

    p_transparent_b_r1: assert property (@(posedge tck) disable iff (!rst_n)
        (!ctl_mode && b_le) |-> (b_dout == b_din));

    p_hold_a_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (!ctl_mode && !a_le && $past(!ctl_mode && !a_le)) |-> $stable(a_dout));

    p_hold_b_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (!ctl_mode && !b_le && $past(!ctl_mode && !b_le)) |-> $stable(b_dout));

    p_drive_r3: assert property (@(posedge tck) disable iff (!rst_n)
        !ctl_mode |-> ((a_drv == !a_oe_n) && (b_drv == !b_oe_n)));

    p_ctl_hold_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (ctl_mode && $past(ctl_mode) && !upd_en) |->
        ($stable(a_dout) && $stable(a_drv) && $stable(b_dout) && $stable(b_drv)));

    p_reset_clear_r11: assert property (@(posedge tck) disable iff (!rst_n)
        ($rose(rst_n) && ctl_mode) |->
        (a_dout == '0 && !a_drv && b_dout == '0 && !b_drv));

endmodule

bind scan_dual_latch scan_dual_latch_chk #(.DATA_W(DATA_W)) u_chk (
    .tck     (tck),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .ctl_mode(ctl_mode),
    .a_le    (a_le),
    .a_oe_n  (a_oe_n),
    .a_din   (a_din),
    .b_le    (b_le),
    .b_oe_n  (b_oe_n),
    .b_din   (b_din),
    .a_dout  (a_dout),
    .a_drv   (a_drv),
    .b_dout  (b_dout),
    .b_drv   (b_drv)
);

// File: tb/scan_dual_latch_bench.sv
// Bench: fixed-seed random plus directed cases, expected values from bench models.
module scan_dual_latch_bench;

    localparam int W   = 9;
    localparam int LEN = 6 + 4 * W;

    logic tck = 1'b0;
    logic rst_n = 1'b0, cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0;
    logic ctl_mode = 1'b0, tdi = 1'b0;
    logic a_le = 1'b0, a_oe_n = 1'b1, b_le = 1'b0, b_oe_n = 1'b1;
    logic [W-1:0] a_din = '0, b_din = '0;
    logic [W-1:0] a_dout, b_dout;
    logic a_drv, b_drv, tdo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] m_qa = '0;
    logic [W-1:0] m_qb = '0;

    always #10 tck = ~tck;

    scan_dual_latch #(.DATA_W(W)) u_scan_dual_latch (
        .tck(tck), .rst_n(rst_n), .cap_en(cap_en), .shift_en(shift_en),
        .upd_en(upd_en), .ctl_mode(ctl_mode), .tdi(tdi),
        .a_le(a_le), .a_oe_n(a_oe_n), .a_din(a_din),
        .b_le(b_le), .b_oe_n(b_oe_n), .b_din(b_din),
        .a_dout(a_dout), .a_drv(a_drv), .b_dout(b_dout), .b_drv(b_drv),
        .tdo(tdo)
    );

    task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        #5;
    endtask

    task automatic set_a(input logic le, input logic [W-1:0] d, input logic oe_n);
        a_le = le; a_din = d; a_oe_n = oe_n;
        if (le) m_qa = d;
    endtask

    task automatic set_b(input logic le, input logic [W-1:0] d, input logic oe_n);
        b_le = le; b_din = d; b_oe_n = oe_n;
        if (le) m_qb = d;
    endtask

    task automatic check_core(input string req);
        check_eq(req, 64'(a_dout), 64'(m_qa));
        check_eq(req, 64'(a_drv), 64'(!a_oe_n));
        check_eq(req, 64'(b_dout), 64'(m_qb));
        check_eq(req, 64'(b_drv), 64'(!b_oe_n));
    endtask

    function automatic logic [LEN-1:0] exp_cap();
        logic [LEN-1:0] v;
        v[41] = a_oe_n; v[40] = a_le; v[39] = ~a_oe_n;
        v[38] = b_oe_n; v[37] = b_le; v[36] = ~b_oe_n;
        for (int i = 0; i < W; i++) begin
            v[35-i] = a_din[i];
            v[26-i] = b_din[i];
            v[17-i] = m_qa[i];
            v[8-i]  = m_qb[i];
        end
        return v;
    endfunction

    task automatic check_ctl(input string req, input logic [LEN-1:0] u);
        logic [W-1:0] ea, eb;
        for (int i = 0; i < W; i++) begin
            ea[i] = u[17-i];
            eb[i] = u[8-i];
        end
        check_eq(req, 64'(a_dout), 64'(ea));
        check_eq(req, 64'(a_drv), 64'(u[39]));
        check_eq(req, 64'(b_dout), 64'(eb));
        check_eq(req, 64'(b_drv), 64'(u[36]));
    endtask

    task automatic scan_dr(input logic [LEN-1:0] vin, input bit do_cap, input bit do_upd,
                           output logic [LEN-1:0] vout);
        if (do_cap) begin
            cap_en = 1'b1; step(); cap_en = 1'b0;
        end
        for (int k = 0; k < LEN; k++) begin
            shift_en = 1'b1;
            tdi = vin[k];
            step();
            vout[k] = tdo;
        end
        shift_en = 1'b0;
        if (do_upd) begin
            upd_en = 1'b1; step(); upd_en = 1'b0;
        end
    endtask

    initial begin
        repeat (50000) @(posedge tck);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [LEN-1:0] vout, u, u2, p1, p2;
        void'($urandom(32'd7351));

        // R11: reset clears update stage and tdo
        ctl_mode = 1'b1;
        repeat (4) step();
        check_ctl("R11", '0);
        check_eq("R11", 64'(tdo), 64'd0);
        rst_n = 1'b1;
        step();
        check_ctl("R11", '0);
        ctl_mode = 1'b0;

        // R1 / R3 directed
        set_a(1'b1, 9'h1A5, 1'b0); set_b(1'b1, 9'h04B, 1'b0); step();
        check_eq("R1", 64'(a_dout), 64'h1A5);
        check_eq("R1", 64'(b_dout), 64'h04B);
        check_eq("R3", 64'(a_drv), 64'd1);
        // R2 hold
        set_a(1'b0, 9'h0F0, 1'b0); step();
        check_eq("R2", 64'(a_dout), 64'h1A5);
        // R3 undriven but loading
        set_a(1'b0, 9'h0F0, 1'b1); step();
        check_eq("R3", 64'(a_drv), 64'd0);
        set_a(1'b1, 9'h05A, 1'b1); step();
        check_eq("R3", 64'(a_dout), 64'h05A);
        check_eq("R3", 64'(a_drv), 64'd0);
        set_a(1'b0, 9'h111, 1'b1); step();
        set_a(1'b0, 9'h111, 1'b0); step();
        check_eq("R3", 64'(a_dout), 64'h05A);
        check_eq("R3", 64'(a_drv), 64'd1);
        // R4 independence
        set_b(1'b1, 9'h1FF, 1'b1); step();
        check_eq("R4", 64'(a_dout), 64'h05A);
        check_eq("R4", 64'(a_drv), 64'd1);
        check_eq("R4", 64'(b_dout), 64'h1FF);
        set_b(1'b0, 9'h000, 1'b0); step();

        // R1 R2 R3 R4 random
        for (int n = 0; n < 60; n++) begin
            if ($urandom_range(1) == 0)
                set_a(1'($urandom()), W'($urandom()), 1'($urandom()));
            else
                set_b(1'($urandom()), W'($urandom()), 1'($urandom()));
            step();
            check_core("R1 R2 R3 R4 random");
        end

        // R5 capture order, R10 outputs untouched in normal mode
        set_a(1'b1, 9'h0C3, 1'b0); step();
        set_a(1'b0, 9'h1AA, 1'b0);
        set_b(1'b1, 9'h13C, 1'b1); step();
        scan_dr(LEN'({$urandom(), $urandom()}), 1'b1, 1'b0, vout);
        check_eq("R5", 64'(vout), 64'(exp_cap()));
        check_core("R10");

        // R8 update drives outputs in control mode
        u = 42'h2AB_5C3E_91D7 & {LEN{1'b1}};
        scan_dr(u, 1'b1, 1'b1, vout);
        check_core("R10");
        ctl_mode = 1'b1; step();
        check_ctl("R8", u);
        ctl_mode = 1'b0; step();
        check_core("R10");

        // R9 update stage holds without upd_en
        ctl_mode = 1'b1; step();
        u2 = ~u;
        scan_dr(u2, 1'b1, 1'b0, vout);
        check_ctl("R9", u);

        // R12 latches keep loading under override; capture sees latches
        set_a(1'b1, 9'h0E1, 1'b0); set_b(1'b1, 9'h11E, 1'b0); step();
        check_ctl("R8", u);
        set_a(1'b0, 9'h00F, 1'b0); set_b(1'b0, 9'h1F0, 1'b0); step();
        scan_dr(u2, 1'b1, 1'b0, vout);
        check_eq("R12", 64'(vout), 64'(exp_cap()));

        // R6 pure shift, 42-bit length
        p1 = 42'h155_2A3C_4D5E;
        p2 = 42'h0F0_F0F0_F0F1;
        scan_dr(p1, 1'b0, 1'b0, vout);
        scan_dr(p2, 1'b0, 1'b0, vout);
        check_eq("R6", 64'(vout), 64'(p1));

        // R7 tdo changes on the falling edge only (chain bit 0 = B latch bit 8)
        set_b(1'b1, 9'h0FF, 1'b0); step();
        check_eq("R7", 64'(tdo), 64'd1);
        cap_en = 1'b1; step(); cap_en = 1'b0;
        check_eq("R7", 64'(tdo), 64'd1);
        @(negedge tck); #5;
        check_eq("R7", 64'(tdo), 64'd0);
        step();

        // R8 random update patterns
        for (int n = 0; n < 8; n++) begin
            u = LEN'({$urandom(), $urandom()});
            scan_dr(u, 1'b1, 1'b1, vout);
            step();
            check_ctl("R8 random", u);
        end

        // R11 mid-run reset
        rst_n = 1'b0; step(); step();
        rst_n = 1'b1; step();
        check_ctl("R11", '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule